// File: doc/BRIEF.md
# Slot-Masked TDM Auto-Buffer Port

This block is a time-division-multiplexed serial port. It works in frames of 32 time slots of 8 bits each, which gives 256 bit cycles per frame. One bit moves per clock cycle, most significant bit first. A shared frame-sync input, asserted in the cycle just before the first bit of slot 0, fixes the slot grid for both directions.

The receive side and the transmit side each have their own 32-bit slot mask. Mask bit n controls slot n. A byte received in an enabled slot is written, right-justified and zero-extended, into a 16-bit buffer word. The writes go to consecutive addresses of a circular receive buffer in local memory. The transmit side reads consecutive words of a second circular buffer and shifts them out in the enabled slots. It leaves the line undriven in every other slot.

Each buffer has its own programmable length, from 1 to 32. A pointer moves only on enabled slots. When a pointer passes its final location, it returns to 0 and raises a one-cycle interrupt for that direction. Software therefore services each buffer once per wrap, not once per word. For example, a receive mask that enables the first two slots of every group of four, with a length of 16, collects 16 words per frame.

Top module: `tdm_abuf_port`

## Requirements
- R1: When `fsync` is high in a cycle while `en` is high, the next cycle carries bit 7 of slot 0. Slot n occupies cycles 8n to 8n+7 after that point, and the frame repeats by count every 256 cycles until the next `fsync`.
- R2: For an enabled receive slot, the eight bits sampled on `rx_sd` (first bit = bit 7) are written with `rx_we` high in the cycle after the slot's last bit. `rx_wdata[7:0]` holds the byte and `rx_wdata[15:8]` is zero.
- R3: A slot whose `rx_mask` bit is 0 produces no write and does not move the receive pointer.
- R4: Receive writes go to addresses 0, 1, 2, … and return to 0 after address `rx_len`-1.
- R5: `rx_irq` is a one-cycle pulse, high together with the write to address `rx_len`-1 and at no other time.
- R6: For an enabled transmit slot, `tx_oe` is high for the slot's 8 cycles. `tx_sd` carries `tx_rdata` (read at address `tx_raddr`) MSB first. `tx_raddr` advances by one in the slot's first cycle and returns to 0 after `tx_len`-1.
- R7: In a slot whose `tx_mask` bit is 0, `tx_oe` and `tx_sd` are 0 and `tx_raddr` holds.
- R8: `tx_irq` is a one-cycle pulse in the first cycle of the slot that sends the word at address `tx_len`-1.
- R9: While `en` is low, both pointers are 0 and there are no writes, no output enable and no interrupts, whatever `fsync` and `rx_sd` do. After `en` rises, nothing moves until the next `fsync`, and both buffers then start at address 0.
- R10: The receive and transmit masks and lengths act independently of each other.
- R11: After reset, `rx_we`, `tx_oe`, `tx_sd`, `rx_irq`, `tx_irq` and `tx_raddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low clears pointers and framing |
| fsync | input | 1 | Frame sync, high in the cycle before slot 0 bit 7 |
| rx_mask | input | 32 | Receive slot enables, bit n = slot n |
| tx_mask | input | 32 | Transmit slot enables, bit n = slot n |
| rx_len | input | 6 | Receive buffer length, 1 to 32 |
| tx_len | input | 6 | Transmit buffer length, 1 to 32 |
| rx_sd | input | 1 | Serial receive data |
| tx_sd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit drive enable |
| rx_we | output | 1 | Receive buffer write strobe |
| rx_waddr | output | 5 | Receive buffer write address |
| rx_wdata | output | 16 | Receive buffer write data, zero-extended byte |
| tx_raddr | output | 5 | Transmit buffer read address |
| tx_rdata | input | 8 | Transmit word read at `tx_raddr`, one cycle latency |
| rx_irq | output | 1 | Receive buffer wrap pulse |
| tx_irq | output | 1 | Transmit buffer wrap pulse |

## Verification
The bench uses sparse masks, so a design that advanced its pointers on every slot, or wrote the skipped slots, would produce extra or misaddressed writes and shifted transmit words. A length of 3 forces the pointer to wrap in the middle of a frame, and a length of 16 makes it wrap exactly at the frame edge. An off-by-one wrap comparison would show up as an address of `len` or an interrupt one word early or late. Dropping `en` in the middle of a frame while `fsync` keeps toggling catches pointers that survive a disable or framing that restarts without a new sync.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int NSLOT_DEF  = 32;
  localparam int SLOT_W_DEF = 8;
  localparam int MEM_W_DEF  = 16;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int NSLOT  = tdm_pkg::NSLOT_DEF,
  parameter int SLOT_W = tdm_pkg::SLOT_W_DEF,
  localparam int FRAME = NSLOT * SLOT_W,
  localparam int POS_W = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fsync,
  output logic [POS_W-1:0] pos,
  output logic             framed,
  output logic [POS_W-1:0] nxt_pos,
  output logic             nxt_valid
);
  logic at_end;
  assign at_end    = (pos == POS_W'(FRAME - 1));
  assign nxt_pos   = (fsync || at_end) ? '0 : pos + POS_W'(1);
  assign nxt_valid = en && (fsync || framed);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos    <= '0;
      framed <= 1'b0;
    end else if (fsync) begin
      pos    <= '0;
      framed <= 1'b1;
    end else if (framed) begin
      pos    <= nxt_pos;
    end
  end

  // R1: a sync always lands the grid on position 0
  a_r1_sync_origin: assert property (@(posedge clk) disable iff (rst)
    (en && fsync) |=> (framed && pos == '0));
endmodule

// File: rtl/tdm_ring_ptr.sv
module tdm_ring_ptr #(
  parameter int DEPTH = tdm_pkg::NSLOT_DEF,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              adv,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] ptr,
  output logic              wrap
);
  logic [LEN_W-1:0] ptr_inc;
  assign ptr_inc = LEN_W'(ptr) + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ptr  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (adv) begin
        if (ptr_inc >= len) begin
          ptr  <= '0;
          wrap <= 1'b1;
        end else begin
          ptr  <= ADDR_W'(ptr_inc);
        end
      end
    end
  end

  // R4: a wrap pulse always leaves the pointer back at the start
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (ptr == '0));
  // R5: wrap is only ever the result of an advance
  a_r5_wrap_needs_adv: assert property (@(posedge clk) disable iff (rst)
    wrap |-> $past(adv));
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
  parameter int NSLOT  = tdm_pkg::NSLOT_DEF,
  parameter int SLOT_W = tdm_pkg::SLOT_W_DEF,
  parameter int MEM_W  = tdm_pkg::MEM_W_DEF,
  localparam int POS_W  = $clog2(NSLOT * SLOT_W),
  localparam int BIT_W  = $clog2(SLOT_W),
  localparam int ADDR_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [POS_W-1:0]  pos,
  input  logic              framed,
  input  logic              sd,
  input  logic [NSLOT-1:0]  mask,
  input  logic [ADDR_W-1:0] ptr,
  output logic              adv,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [MEM_W-1:0]  wdata
);
  logic [SLOT_W-2:0] shreg;
  logic [BIT_W-1:0]  bit_idx;
  logic [ADDR_W-1:0] slot;

  assign bit_idx = pos[BIT_W-1:0];
  assign slot    = pos[POS_W-1:BIT_W];
  assign adv     = en && framed && (bit_idx == BIT_W'(SLOT_W - 1)) && mask[slot];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      shreg <= '0;
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      if (framed) shreg <= {shreg[SLOT_W-3:0], sd};
      we <= adv;
      if (adv) begin
        waddr <= ptr;
        wdata <= {{(MEM_W - SLOT_W){1'b0}}, shreg, sd};
      end
    end
  end

  // R2: a write only ever appears at the start of the following slot
  a_r2_write_at_slot_edge: assert property (@(posedge clk) disable iff (rst)
    we |-> (pos[BIT_W-1:0] == '0));
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int NSLOT  = tdm_pkg::NSLOT_DEF,
  parameter int SLOT_W = tdm_pkg::SLOT_W_DEF,
  localparam int POS_W  = $clog2(NSLOT * SLOT_W),
  localparam int BIT_W  = $clog2(SLOT_W),
  localparam int ADDR_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [POS_W-1:0]  nxt_pos,
  input  logic              nxt_valid,
  input  logic [NSLOT-1:0]  mask,
  input  logic [SLOT_W-1:0] rdata,
  output logic              adv,
  output logic              sd,
  output logic              oe
);
  logic [SLOT_W-1:0] shreg;
  logic [ADDR_W-1:0] nslot;
  logic              start;

  assign nslot = nxt_pos[POS_W-1:BIT_W];
  assign start = nxt_valid && (nxt_pos[BIT_W-1:0] == '0);
  assign adv   = start && mask[nslot];
  assign sd    = shreg[SLOT_W-1];

  always_ff @(posedge clk) begin
    if (rst || !en || !nxt_valid) begin
      shreg <= '0;
      oe    <= 1'b0;
    end else if (start) begin
      oe    <= mask[nslot];
      shreg <= mask[nslot] ? rdata : '0;
    end else begin
      shreg <= {shreg[SLOT_W-2:0], 1'b0};
    end
  end

  // R7: the data line stays low whenever it is not driven
  a_r7_silent_when_undriven: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !sd);
endmodule

// File: rtl/tdm_abuf_port.sv
module tdm_abuf_port #(
  parameter int NSLOT  = tdm_pkg::NSLOT_DEF,
  parameter int SLOT_W = tdm_pkg::SLOT_W_DEF,
  parameter int MEM_W  = tdm_pkg::MEM_W_DEF,
  localparam int POS_W  = $clog2(NSLOT * SLOT_W),
  localparam int BIT_W  = $clog2(SLOT_W),
  localparam int ADDR_W = $clog2(NSLOT),
  localparam int LEN_W  = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fsync,
  input  logic [NSLOT-1:0]  rx_mask,
  input  logic [NSLOT-1:0]  tx_mask,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              rx_sd,
  output logic              tx_sd,
  output logic              tx_oe,
  output logic              rx_we,
  output logic [ADDR_W-1:0] rx_waddr,
  output logic [MEM_W-1:0]  rx_wdata,
  output logic [ADDR_W-1:0] tx_raddr,
  input  logic [SLOT_W-1:0] tx_rdata,
  output logic              rx_irq,
  output logic              tx_irq
);
  logic [POS_W-1:0]  pos, nxt_pos;
  logic              framed, nxt_valid;
  logic              rx_adv, tx_adv;
  logic [ADDR_W-1:0] rx_ptr;

  tdm_frame_timer #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .en(en), .fsync(fsync),
    .pos(pos), .framed(framed), .nxt_pos(nxt_pos), .nxt_valid(nxt_valid)
  );

  tdm_ring_ptr #(.DEPTH(NSLOT)) u_rx_ring (
    .clk(clk), .rst(rst), .en(en), .adv(rx_adv), .len(rx_len),
    .ptr(rx_ptr), .wrap(rx_irq)
  );

  tdm_ring_ptr #(.DEPTH(NSLOT)) u_tx_ring (
    .clk(clk), .rst(rst), .en(en), .adv(tx_adv), .len(tx_len),
    .ptr(tx_raddr), .wrap(tx_irq)
  );

  tdm_rx_lane #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .MEM_W(MEM_W)) u_rx (
    .clk(clk), .rst(rst), .en(en), .pos(pos), .framed(framed), .sd(rx_sd),
    .mask(rx_mask), .ptr(rx_ptr), .adv(rx_adv),
    .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata)
  );

  tdm_tx_lane #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst(rst), .en(en), .nxt_pos(nxt_pos), .nxt_valid(nxt_valid),
    .mask(tx_mask), .rdata(tx_rdata), .adv(tx_adv), .sd(tx_sd), .oe(tx_oe)
  );

  // R5: the receive interrupt rides on a buffer write
  a_r5_irq_with_write: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_we);
  // R8: the transmit interrupt marks the first bit of a driven slot
  a_r8_tx_irq_slot_start: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (tx_oe && pos[BIT_W-1:0] == '0));
  // R9: a disabled port is fully quiet one cycle later
  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!rx_we && !tx_oe && !rx_irq && !tx_irq && tx_raddr == '0));
  // R6: drive enable only changes on slot boundaries while running
  a_r6_oe_on_boundary: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(tx_oe)) |-> (pos[BIT_W-1:0] == '0));
endmodule

// File: tb/tdm_abuf_port_tb.sv
module tdm_abuf_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1, en = 1'b0, fsync = 1'b0, rx_sd = 1'b0;
  logic [31:0] rx_mask = '0, tx_mask = '0;
  logic [5:0]  rx_len = 6'd32, tx_len = 6'd32;
  logic        tx_sd, tx_oe, rx_we, rx_irq, tx_irq;
  logic [4:0]  rx_waddr, tx_raddr;
  logic [15:0] rx_wdata;
  logic [7:0]  tx_rdata = '0;

  int n_run = 0, n_fail = 0, cyc = 0;
  int rx_ptr_m = 0, tx_ptr_m = 0;
  logic [7:0] txmem [32];
  logic [7:0] rxb   [32];

  typedef struct { int c; logic irq; logic [4:0] a; logic [15:0] d; } rx_exp_t;
  rx_exp_t exq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) tx_rdata <= txmem[tx_raddr];

  tdm_abuf_port u_dut (
    .clk(clk), .rst(rst), .en(en), .fsync(fsync),
    .rx_mask(rx_mask), .tx_mask(tx_mask), .rx_len(rx_len), .tx_len(tx_len),
    .rx_sd(rx_sd), .tx_sd(tx_sd), .tx_oe(tx_oe),
    .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wdata(rx_wdata),
    .tx_raddr(tx_raddr), .tx_rdata(tx_rdata), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: every receive write is popped from the scoreboard and compared
  always @(negedge clk) begin
    if (!rst && (rx_we || rx_irq)) begin
      if (exq.size() == 0) begin
        chk("R3 R9 unexpected write addr", {26'd0, rx_irq, rx_waddr}, 32'hffff_ffff);
      end else begin
        rx_exp_t e;
        e = exq.pop_front();
        chk("R2 write data", rx_wdata, e.d);
        chk("R4 write addr", rx_waddr, e.a);
        chk("R5 rx irq", rx_irq, e.irq);
        chk("R2 write cycle", cyc, e.c);
        chk("R2 write strobe", rx_we, 1'b1);
      end
    end
  end

  // driver: runs frames back to back; stop_at aborts by dropping en
  task automatic run_frames(input int nfr, input int stop_at);
    logic [7:0] txw = '0;
    rx_ptr_m = 0; tx_ptr_m = 0;
    @(negedge clk); fsync = 1'b1; rx_sd = 1'b0;
    for (int g = 0; g < nfr * 256; g++) begin
      int i, s, b;
      logic exp_irq;
      @(negedge clk);
      if (g == stop_at) begin en = 1'b0; fsync = 1'b0; return; end
      i = g % 256; s = i / 8; b = i % 8;
      if (i == 0) for (int k = 0; k < 32; k++) rxb[k] = 8'($urandom);
      if (b == 0) begin
        exp_irq = 1'b0;
        if (tx_mask[s]) begin
          txw = txmem[tx_ptr_m];
          exp_irq = (tx_ptr_m == int'(tx_len) - 1);
          tx_ptr_m = exp_irq ? 0 : tx_ptr_m + 1;
        end else txw = '0;
        chk("R8 tx irq", tx_irq, exp_irq);
        chk("R6 R7 tx read addr", tx_raddr, tx_ptr_m);
      end
      chk("R1 R6 R7 tx enable", tx_oe, tx_mask[s]);
      chk("R1 R6 R7 tx bit", tx_sd, tx_mask[s] ? txw[7-b] : 1'b0);
      rx_sd = rxb[s][7-b];
      fsync = (i == 255) && (g != nfr * 256 - 1);
      if (b == 7 && rx_mask[s]) begin
        rx_exp_t e;
        e.c = cyc + 1; e.a = 5'(rx_ptr_m); e.d = {8'h00, rxb[s]};
        e.irq = (rx_ptr_m == int'(rx_len) - 1);
        exq.push_back(e);
        rx_ptr_m = e.irq ? 0 : rx_ptr_m + 1;
      end
    end
  endtask

  task automatic phase_end();
    @(negedge clk); en = 1'b0; fsync = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 all writes seen", exq.size(), 0);
    chk("R9 tx addr cleared", tx_raddr, 0);
    chk("R9 tx enable off", tx_oe, 0);
  endtask

  task automatic start(input logic [31:0] rm, input logic [31:0] tm,
                       input logic [5:0] rl, input logic [5:0] tl);
    rx_mask = rm; tx_mask = tm; rx_len = rl; tx_len = tl;
    @(negedge clk); en = 1'b1;
  endtask

  initial begin
    for (int k = 0; k < 32; k++) txmem[k] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 rx_we", rx_we, 0);   chk("R11 tx_oe", tx_oe, 0);
    chk("R11 tx_sd", tx_sd, 0);   chk("R11 rx_irq", rx_irq, 0);
    chk("R11 tx_irq", tx_irq, 0); chk("R11 tx_raddr", tx_raddr, 0);

    // all slots, full length, two frames
    start(32'hffff_ffff, 32'hffff_ffff, 6'd32, 6'd32);
    run_frames(2, -1); phase_end();

    // first two slots of every four, length 16 (R3 R7 R4)
    start(32'h3333_3333, 32'h3333_3333, 6'd16, 6'd16);
    run_frames(2, -1); phase_end();

    // R10: independent masks; short lengths wrap mid-frame
    start(32'h0000_00f0, 32'h8000_0101, 6'd3, 6'd2);
    run_frames(2, -1); phase_end();

    // R9: abort mid-frame, keep toggling sync while off, restart at 0
    start(32'h5555_5555, 32'haaaa_aaaa, 6'd5, 6'd7);
    run_frames(1, 100);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); fsync = (k == 2); rx_sd = k[0];
      chk("R9 off tx enable", tx_oe, 0);
      chk("R9 off tx addr", tx_raddr, 0);
      chk("R9 off irqs", {rx_irq, tx_irq}, 0);
    end
    fsync = 1'b0;
    @(negedge clk); en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 waits for sync", tx_oe, 0);
    run_frames(1, -1); phase_end();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule